// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the bus-facing protocol engine for a small serial nonvolatile memory. It sits on a fast system clock and watches the two bus lines, SCL and SDA. Each line is synchronised and then filtered, so that a pulse shorter than a set number of system clocks never reaches the protocol logic. From the clean levels the block finds start and stop conditions and clock edges. It receives a device byte, checks it against a fixed type code of 1010 and three strap pins, and answers a match by pulling SDA low for the ninth clock. SDA is only ever pulled low. The block never drives it high.

In a write transaction, the byte after the device byte is a word address. The controller loads its low seven bits into the external address counter. Every data byte after that is handed to the external write engine with a push strobe and a counter increment. A stop that ends a transaction carrying write data issues a commit strobe. In a read transaction, the block fetches a byte through its read strobe and shifts it out MSB first. After each byte it samples the master's ninth bit. A low bit means the next byte follows. A high bit means the block lets go of the bus. A repeated start after a word address therefore turns the transaction into a random read. While the write engine reports busy, the device byte is not acknowledged, so the master can poll for completion.

Top module: `tws_mem_slave`

## Requirements
- R1: While reset is held, sda_drive_low, addr_load, addr_inc, rd_take, wr_push and wr_commit are all 0.
- R2: A device byte is accepted only when its bits 7:4 equal 1010 and its bits 3:1 equal strap[2:0]. Bit 0 selects read (1) or write (0). On any other device byte the block stays released and makes no strobe until the next start.
- R3: After an accepted device byte, and after every byte received in write mode, sda_drive_low is 1 throughout the ninth SCL high period.
- R4: In write mode, the first byte after the device byte pulses addr_load with addr_val equal to that byte's bits 6:0; bit 7 is ignored. Each later byte pulses wr_push with wr_byte equal to the byte, together with addr_inc.
- R5: In read mode, each byte is taken from rd_data with one rd_take and one addr_inc pulse, and sent MSB first, with a 0 bit driven as a low pull. When the master's ninth bit is low, the next byte follows. When it is high, SDA stays released until the next start or stop.
- R6: A stop returns the block to idle. It pulses wr_commit for exactly one cycle if, and only if, at least one data byte was received since the last start.
- R7: While wr_busy is 1, a matching device byte is not acknowledged.
- R8: A repeated start after a write-mode word address, followed by a read device byte, returns the data at that word address first.
- R9: A low pulse on SDA that lasts fewer than FILT_LEN system clocks while SCL is high is not taken as a start.
- R10: A start that arrives partway through a byte drops that byte and restarts device-byte reception.
- R11: sda_drive_low changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired level) |
| strap | input | 3 | Device select pins, compared with device byte bits 3:1 |
| wr_busy | input | 1 | Write engine busy with an internal cycle |
| rd_data | input | 8 | Array byte at the current counter address |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_load | output | 1 | One-cycle strobe loading addr_val into the address counter |
| addr_val | output | 7 | Word address to load |
| addr_inc | output | 1 | One-cycle strobe advancing the address counter |
| rd_take | output | 1 | One-cycle strobe: rd_data captured for sending |
| wr_push | output | 1 | One-cycle strobe: wr_byte is a received data byte |
| wr_byte | output | 8 | Received data byte |
| wr_commit | output | 1 | One-cycle strobe: start the internal write cycle |

## Verification
The hardest case to reach from the ports is a condition that exists only at a precise spot in the bus sequence. Examples are a start that lands between two bits of a byte, a glitch on SDA that is shorter than the filter, and a device byte that arrives while the write engine is still busy. The bench drives SCL and SDA at bit level with a wired-AND model. That lets it cut a byte off after four bits, hold SDA low for two system clocks, or poll right after a committing stop. A behavioural counter and array around the block turn its strobes into stored bytes and returned data.

// File: rtl/tws_pkg.sv
// Package: shared constants and the protocol phase type for the two-wire
// memory slave. Assumes a single fixed four-bit device type code.
package tws_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // waiting for a start
        PH_DEV  = 3'd1,   // receiving device byte
        PH_WORD = 3'd2,   // receiving word address
        PH_DATA = 3'd3,   // receiving write data
        PH_TX   = 3'd4,   // sending read data
        PH_SKIP = 3'd5    // not addressed or read ended: wait for start/stop
    } phase_t;
endpackage

// File: rtl/tws_glitch_filter.sv
// Module: two-flop synchroniser followed by a persistence filter. The output
// follows the input only after the synchronised input has differed from the
// output for FILT_LEN consecutive clocks. Assumes FILT_LEN >= 1.
module tws_glitch_filter #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run_cnt;

    // Synchronise the asynchronous pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= RST_VAL;
            s2 <= RST_VAL;
        end else begin
            s1 <= raw_in;
            s2 <= s1;
        end
    end

    // Count clocks of disagreement and flip the output once it persists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            clean_out <= RST_VAL;
        end else if (s2 == clean_out) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_LEN - 1)) begin
            run_cnt   <= '0;
            clean_out <= s2;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // The output may only ever move towards the value the input held.
    assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean_out) |-> (clean_out == $past(s2)));
endmodule

// File: rtl/tws_line_monitor.sv
// Module: cleans both bus lines and derives clock edges and start/stop events
// from the filtered levels. Assumes an idle bus reads high on both lines.
module tws_line_monitor #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;
    logic              scl_q, sda_q;

    assign raw_lines = {sda_in, scl_in};

    // One filter per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        tws_glitch_filter #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (1'b1)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (raw_lines[g]),
            .clean_out (clean_lines[g])
        );
    end

    assign scl_lvl = clean_lines[0];
    assign sda_lvl = clean_lines[1];

    // Hold the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    // Decode clock edges and data transitions under a high clock.
    always_comb begin
        scl_rise = scl_lvl && !scl_q;
        scl_fall = !scl_lvl && scl_q;
        start_ev = scl_lvl && scl_q && sda_q && !sda_lvl;
        stop_ev  = scl_lvl && scl_q && !sda_q && sda_lvl;
    end
endmodule

// File: rtl/tws_proto_fsm.sv
// Module: byte-level protocol sequencer. Works on filtered bus events, shifts
// bytes in on SCL rise and out on SCL fall, and issues strobes to the address
// counter, array and write engine. Assumes rd_data reflects the counter
// address combinationally and that the counter updates on addr_load/addr_inc.
module tws_proto_fsm
    import tws_pkg::*;
#(
    parameter int STRAP_W = 3,
    parameter int AW      = 7,
    parameter int DW      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_busy,
    input  logic [DW-1:0]      rd_data,
    output logic               sda_drive_low,
    output logic               addr_load,
    output logic [AW-1:0]      addr_val,
    output logic               addr_inc,
    output logic               rd_take,
    output logic               wr_push,
    output logic [DW-1:0]      wr_byte,
    output logic               wr_commit
);
    localparam int          BCW      = $clog2(DW + 2);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);
    localparam logic [BCW-1:0] ACK_SLOT = BCW'(DW);
    localparam logic [BCW-1:0] ACK_DONE = BCW'(DW + 1);

    phase_t         phase;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0]  shreg;
    logic [DW-1:0]  rx_byte;
    logic           rw_bit;
    logic           got_data;
    logic           dev_match;

    // Byte as it stands once the current rising-edge bit is included.
    assign rx_byte   = {shreg[DW-2:0], sda_lvl};
    assign dev_match = (rx_byte[DW-1:DW-4] == DEV_TYPE) &&
                       (rx_byte[STRAP_W:1] == strap) && !wr_busy;

    // Main sequencer: bus events first, then clock edges by phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase         <= PH_IDLE;
            bitcnt        <= '0;
            shreg         <= '0;
            rw_bit        <= 1'b0;
            got_data      <= 1'b0;
            sda_drive_low <= 1'b0;
            addr_load     <= 1'b0;
            addr_val      <= '0;
            addr_inc      <= 1'b0;
            rd_take       <= 1'b0;
            wr_push       <= 1'b0;
            wr_byte       <= '0;
            wr_commit     <= 1'b0;
        end else begin
            addr_load <= 1'b0;
            addr_inc  <= 1'b0;
            rd_take   <= 1'b0;
            wr_push   <= 1'b0;
            wr_commit <= 1'b0;
            if (start_ev) begin
                phase         <= PH_DEV;
                bitcnt        <= '0;
                got_data      <= 1'b0;
                sda_drive_low <= 1'b0;
            end else if (stop_ev) begin
                phase         <= PH_IDLE;
                bitcnt        <= '0;
                sda_drive_low <= 1'b0;
                wr_commit     <= got_data;
                got_data      <= 1'b0;
            end else if (scl_rise) begin
                case (phase)
                    PH_DEV, PH_WORD, PH_DATA: begin
                        if (bitcnt < ACK_SLOT) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                if (phase == PH_DEV) begin
                                    if (dev_match) rw_bit <= rx_byte[0];
                                    else           phase  <= PH_SKIP;
                                end else if (phase == PH_WORD) begin
                                    addr_load <= 1'b1;
                                    addr_val  <= rx_byte[AW-1:0];
                                end else begin
                                    wr_push  <= 1'b1;
                                    wr_byte  <= rx_byte;
                                    addr_inc <= 1'b1;
                                    got_data <= 1'b1;
                                end
                            end
                        end
                    end
                    PH_TX: begin
                        if (bitcnt < ACK_SLOT) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (bitcnt == ACK_SLOT) begin
                            if (sda_lvl) phase  <= PH_SKIP;
                            else         bitcnt <= ACK_DONE;
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (phase)
                    PH_DEV, PH_WORD, PH_DATA: begin
                        if (bitcnt == ACK_SLOT) begin
                            sda_drive_low <= 1'b1;
                            bitcnt        <= ACK_DONE;
                        end else if (bitcnt == ACK_DONE) begin
                            sda_drive_low <= 1'b0;
                            bitcnt        <= '0;
                            if (phase == PH_DEV) begin
                                if (rw_bit) begin
                                    phase         <= PH_TX;
                                    shreg         <= rd_data;
                                    sda_drive_low <= !rd_data[DW-1];
                                    rd_take       <= 1'b1;
                                    addr_inc      <= 1'b1;
                                end else begin
                                    phase <= PH_WORD;
                                end
                            end else if (phase == PH_WORD) begin
                                phase <= PH_DATA;
                            end
                        end
                    end
                    PH_TX: begin
                        if (bitcnt == ACK_SLOT) begin
                            sda_drive_low <= 1'b0;
                        end else if (bitcnt == ACK_DONE) begin
                            bitcnt        <= '0;
                            shreg         <= rd_data;
                            sda_drive_low <= !rd_data[DW-1];
                            rd_take       <= 1'b1;
                            addr_inc      <= 1'b1;
                        end else if (bitcnt != '0) begin
                            shreg         <= shreg << 1;
                            sda_drive_low <= !shreg[DW-2];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // An accepted device byte is always followed by an acknowledge pull.
    assert_ack_device_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEV && bitcnt == ACK_SLOT && scl_fall && !start_ev && !stop_ev)
        |=> sda_drive_low);

    // A busy write engine forces the device byte to be ignored.
    assert_busy_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEV && scl_rise && bitcnt == LAST_BIT && wr_busy && !start_ev && !stop_ev)
        |=> (phase == PH_SKIP));

    // After eight sent bits the line is released for the master's reply.
    assert_tx_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TX && bitcnt == ACK_SLOT && scl_fall && !start_ev && !stop_ev)
        |=> !sda_drive_low);

    // The commit strobe lasts a single cycle.
    assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    // Loading an address and pushing data never coincide.
    assert_load_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> !wr_push);

    // The pull-down only moves while the clock line is low.
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_lvl);
endmodule

// File: rtl/tws_mem_slave.sv
// Module: top of the two-wire memory slave controller. Joins the line monitor
// to the protocol sequencer. Assumes sda_in is the wired level of the bus,
// including this block's own pull-down.
module tws_mem_slave #(
    parameter int FILT_LEN = 4,
    parameter int STRAP_W  = 3,
    parameter int AW       = 7,
    parameter int DW       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_busy,
    input  logic [DW-1:0]      rd_data,
    output logic               sda_drive_low,
    output logic               addr_load,
    output logic [AW-1:0]      addr_val,
    output logic               addr_inc,
    output logic               rd_take,
    output logic               wr_push,
    output logic [DW-1:0]      wr_byte,
    output logic               wr_commit
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    tws_line_monitor #(
        .FILT_LEN (FILT_LEN)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tws_proto_fsm #(
        .STRAP_W (STRAP_W),
        .AW      (AW),
        .DW      (DW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_lvl       (scl_lvl),
        .sda_lvl       (sda_lvl),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_ev      (start_ev),
        .stop_ev       (stop_ev),
        .strap         (strap),
        .wr_busy       (wr_busy),
        .rd_data       (rd_data),
        .sda_drive_low (sda_drive_low),
        .addr_load     (addr_load),
        .addr_val      (addr_val),
        .addr_inc      (addr_inc),
        .rd_take       (rd_take),
        .wr_push       (wr_push),
        .wr_byte       (wr_byte),
        .wr_commit     (wr_commit)
    );
endmodule

// File: tb/tb_tws_mem_slave.sv
// Bench: bit-level bus master with wired-AND SDA, a behavioural counter,
// array and busy timer around the block, a table of device-byte vectors,
// then directed transactions.
module tb_tws_mem_slave;
    localparam int Q        = 25;     // quarter bus period in system clocks
    localparam int BUSY_CYC = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       wr_busy;
    logic [7:0] rd_data;
    logic       drv, addr_load, addr_inc, rd_take, wr_push, wr_commit;
    logic [6:0] addr_val;
    logic [7:0] wr_byte;
    logic       sda_bus;

    int errors = 0;
    int checks = 0;
    int commits = 0;
    int r11_bad = 0;
    int busy_cnt = 0;
    logic [6:0] cnt = '0;
    logic [7:0] mem [128];

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~drv;

    tws_mem_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .strap(strap), .wr_busy(wr_busy), .rd_data(rd_data),
        .sda_drive_low(drv), .addr_load(addr_load), .addr_val(addr_val),
        .addr_inc(addr_inc), .rd_take(rd_take), .wr_push(wr_push),
        .wr_byte(wr_byte), .wr_commit(wr_commit)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    initial for (int i = 0; i < 128; i++) mem[i] = init_val(i);

    // Environment: address counter, array, write engine busy timer.
    assign rd_data = mem[cnt];
    assign wr_busy = (busy_cnt != 0);
    always @(posedge clk) begin
        if (addr_load) cnt <= addr_val;
        else if (addr_inc) cnt <= wr_push ? {cnt[6:2], cnt[1:0] + 2'd1} : cnt + 7'd1;
        if (wr_push) mem[cnt] <= wr_byte;
        if (wr_commit) begin commits <= commits + 1; busy_cnt <= BUSY_CYC; end
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end

    // R11 monitor: pull-down must not move while SCL stays high.
    logic prev_scl = 1'b1, prev_drv = 1'b0;
    always @(posedge clk) begin
        if (rst_n && m_scl && prev_scl && (drv != prev_drv)) r11_bad <= r11_bad + 1;
        prev_scl <= m_scl;
        prev_drv <= drv;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #2;
    endtask

    task automatic b_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic b_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic b_bit(input logic b);
        m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask

    task automatic b_send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) b_bit(b[i]);
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_bus; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic b_recv(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b[i] = sda_bus; wq(); m_scl = 1'b0; wq();
        end
        m_sda = ~mack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    endtask

    // Device byte vectors: [8:1] byte on the bus, [0] expected acknowledge.
    localparam logic [8:0] VEC [6] = '{
        {8'hAA, 1'b1},   // 1010 101 W: match
        {8'hA2, 1'b0},   // strap bits 001
        {8'hBA, 1'b0},   // type 1011
        {8'h2A, 1'b0},   // type 0010
        {8'hA8, 1'b0},   // strap bits 100
        {8'hAE, 1'b0}    // strap bits 111
    };

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        int         c0;
        // R1: reset state
        repeat (4) @(posedge clk);
        #2;
        chk(!drv && !addr_load && !addr_inc && !rd_take && !wr_push && !wr_commit,
            "R1 reset outputs", {drv, addr_load, addr_inc, rd_take, wr_push, wr_commit}, 0);
        rst_n = 1'b1;
        wq();

        // R2/R3: device byte table
        for (int v = 0; v < 6; v++) begin
            b_start();
            b_send(VEC[v][8:1], ack);
            chk(ack == VEC[v][0], "R2 R3 device byte ack", ack, VEC[v][0]);
            b_stop();
            wq();
        end
        chk(commits == 0, "R6 no commit without data", commits, 0);

        // R4/R3/R6: byte write, word address MSB ignored
        b_start();
        b_send(8'hAA, ack); chk(ack, "R3 ack device", ack, 1);
        b_send(8'h85, ack); chk(ack, "R3 R4 ack word", ack, 1);
        b_send(8'hC3, ack); chk(ack, "R3 ack data", ack, 1);
        b_stop();
        chk(commits == 1, "R6 commit on stop", commits, 1);

        // R7: poll while busy, then after
        b_start();
        b_send(8'hAA, ack); chk(!ack, "R7 no ack while busy", ack, 0);
        b_stop();
        repeat (BUSY_CYC) @(posedge clk);
        #2;
        chk(mem[5] == 8'hC3, "R4 byte stored at word 05", mem[5], 8'hC3);
        b_start();
        b_send(8'hAA, ack); chk(ack, "R7 ack after busy", ack, 1);
        b_stop();
        chk(commits == 1, "R6 stop without data", commits, 1);

        // R8/R5: random read from 05 with sequential continuation
        b_start();
        b_send(8'hAA, ack);
        b_send(8'h05, ack);
        b_start();
        b_send(8'hAB, ack); chk(ack, "R8 ack read device", ack, 1);
        b_recv(d, 1'b1); chk(d == 8'hC3, "R8 random read data", d, 8'hC3);
        b_recv(d, 1'b0); chk(d == init_val(6), "R5 sequential byte", d, init_val(6));
        wq();
        chk(!drv, "R5 released after master nack", drv, 0);
        b_stop();

        // R5: current address read continues at 07
        b_start();
        b_send(8'hAB, ack);
        b_recv(d, 1'b0); chk(d == init_val(7), "R5 current address read", d, init_val(7));
        b_stop();

        // R5: sequential read across the top of the array
        b_start();
        b_send(8'hAA, ack);
        b_send(8'h7F, ack);
        b_start();
        b_send(8'hAB, ack);
        b_recv(d, 1'b1); chk(d == init_val(127), "R5 read at 7F", d, init_val(127));
        b_recv(d, 1'b0); chk(d == init_val(0), "R5 wrap to 00", d, init_val(0));
        b_stop();

        // R9: short SDA glitch under high SCL is not a start
        wq();
        @(posedge clk); #2; m_sda = 1'b0;
        @(posedge clk); @(posedge clk); #2; m_sda = 1'b1;
        wq();
        m_scl = 1'b0; wq();
        b_send(8'hAA, ack); chk(!ack, "R9 glitch not a start", ack, 0);
        b_stop();

        // R10: start in the middle of a byte restarts reception
        c0 = commits;
        b_start();
        b_bit(1'b1); b_bit(1'b0); b_bit(1'b1); b_bit(1'b1);
        b_start();
        b_send(8'hAA, ack); chk(ack, "R10 ack after mid-byte start", ack, 1);
        b_send(8'h20, ack);
        b_send(8'h3C, ack);
        b_stop();
        chk(commits == c0 + 1, "R10 R6 commit count", commits, c0 + 1);
        repeat (BUSY_CYC + 10) @(posedge clk);
        #2;
        chk(mem[32] == 8'h3C, "R10 byte stored at word 20", mem[32], 8'h3C);

        chk(r11_bad == 0, "R11 drive stable while SCL high", r11_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule